// File: doc/BRIEF.md
# Flash Status-Poll Completion Waiter

This block sits on the host side of a parallel flash device and waits for an embedded program or erase to finish. A one-cycle `start` pulse passes it the location being written (or any location inside the region being erased), the byte that was programmed, and whether the operation is an erase. From then on it repeatedly reads that location through a synchronous request/ready read port. It compares bit 7 of each returned byte with the expected final value of bit 7. While they differ it keeps polling. A set bit 5 means the device reports an internal time limit.

Bit 7 and bit 5 can change in the same read. For that reason, a set bit 5 never ends the wait on its own: the block makes exactly one more read and judges that read's bit 7. Bit 7 can also settle before the other seven bits. So once bit 7 shows the true value, the block reads the byte once more and reports that byte. A host-side limit on the number of polls ends the wait with a fail if the device never answers. A one-cycle `done` pulse then marks the result. The pass flag and the byte stay on the outputs until the next accepted start.

Top module: `flash_poll_waiter`

## Requirements
- R1: Every read request drives `rd_addr` with the address latched at start. `rd_req` stays high with a stable address until a cycle with `rd_ready` high. Once that transfer is done, `rd_req` is low while the block judges the byte and while `done` is high.
- R2: When bit 7 of a polled byte equals the expected bit, the block makes one further read. It then ends with `pass`=1, and `final_data` holds the byte returned by that further read.
- R3: When bit 7 differs from the expected bit and bit 5 (mask 0x20) is 0, the block issues another poll read of the same address.
- R4: When bit 7 differs and bit 5 is 1, the block makes exactly one extra read. If that read's bit 7 matches, the block does the final read of R2 and passes. If it does not match, the block ends with `pass`=0 and `final_data` equal to the extra read's byte, with no further reads.
- R5: For an erase (`is_erase`=1) the expected bit 7 is 1, whatever `exp_data` holds.
- R6: After MAX_POLLS poll reads, each with a bit 7 mismatch and bit 5 equal to 0, the block ends with `pass`=0 and `final_data` equal to the last byte read, with no further reads.
- R7: `done` is high for exactly one cycle per operation. `pass` and `final_data` change only in that cycle and then stay stable until the next accepted start.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. The address used and the result are those of the operation in progress.
- R9: During and after reset, `rd_req`, `done`, `pass` and `final_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin waiting (taken only when idle) |
| op_addr | input | ADDR_W | Address to poll |
| exp_data | input | 8 | Byte that was programmed |
| is_erase | input | 1 | 1 = erase (expected bit 7 is 1) |
| rd_req | output | 1 | Read request, held until ready |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read transfer completes in this cycle |
| rd_data | input | 8 | Read byte, valid with rd_ready |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 = operation completed, 0 = failed |
| final_data | output | 8 | Byte reported with the result |

## Verification
The bench drives a memory model that returns a scripted sequence of bytes, so it can count every read and check its address. The first corner case is bit 5 rising together with a bit 7 mismatch. A design that failed at once on bit 5 would report fail where the extra read would have passed, and a design that ignored bit 5 would keep polling when it should fail. The second is a match on the very first poll. A design that skipped the final read would report the poll byte instead of the settled one. The remaining cases are the erase mode with a contradictory `exp_data`, exhausting the poll limit, a late `start` pulse, and read latency of several cycles. Each shows up as a wrong read count, a wrong result byte, or a result that drifts after `done`.

// File: rtl/flash_poll_pkg.sv
// Package: state encoding shared by the poll waiter modules.
// Assumes nothing beyond SystemVerilog enum support.
package flash_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ1  = 3'd1,
        ST_CHECK1 = 3'd2,
        ST_READ2  = 3'd3,
        ST_CHECK2 = 3'd4,
        ST_FINAL  = 3'd5,
        ST_DONE   = 3'd6
    } poll_state_t;

    localparam int unsigned STATUS_BIT  = 7;
    localparam int unsigned TIMEOUT_BIT = 5;
endpackage

// File: rtl/flash_poll_rdport.sv
// Read port: drives the request/address of the read interface and captures
// the returned byte on each completed transfer.
// Assumes rd_data is valid in any cycle where rd_req and rd_ready are high.
module flash_poll_rdport #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              req_en,
    input  logic              rd_ready,
    input  logic [7:0]        rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              xfer,
    output logic [7:0]        cap_byte
);
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        byte_q;

    // Hold the polled address for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (load_addr) addr_q <= new_addr;
    end

    // Capture the byte of each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (xfer) byte_q <= rd_data;
    end

    // Request and transfer qualification.
    always_comb begin
        rd_req   = req_en;
        rd_addr  = addr_q;
        xfer     = req_en && rd_ready;
        cap_byte = byte_q;
    end
endmodule

// File: rtl/flash_poll_counter.sv
// Poll counter: counts completed first-stage poll reads and flags when the
// host-side limit has been reached.
// Assumes clr and inc are never high in the same cycle.
module flash_poll_counter #(
    parameter int unsigned MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

    logic [CNT_W-1:0] cnt_q;

    // Count polls, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr)                     cnt_q <= '0;
        else if (inc && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
    end

    // Limit flag seen by the sequencer.
    always_comb at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/flash_poll_fsm.sv
// Sequencer: decides after each read whether to poll again, make the extra
// read that follows a timeout indication, do the final settling read, or end.
// Registers the result so it holds from the done pulse until the next start.
// Assumes cap_byte holds the byte of the most recent transfer.
module flash_poll_fsm
    import flash_poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] exp_data,
    input  logic       is_erase,
    input  logic       xfer,
    input  logic [7:0] rd_data,
    input  logic [7:0] cap_byte,
    input  logic       at_limit,
    output logic       accept,
    output logic       req_en,
    output logic       poll_inc,
    output logic       done,
    output logic       pass,
    output logic [7:0] final_data
);
    poll_state_t state_q, state_d;
    logic        exp_bit_q;
    logic        bit_match;
    logic        tmo_seen;
    logic        pass_q;
    logic [7:0]  data_q;

    // Decode the captured byte against the expected status bit.
    always_comb begin
        bit_match = (cap_byte[STATUS_BIT] == exp_bit_q);
        tmo_seen  = cap_byte[TIMEOUT_BIT];
        accept    = (state_q == ST_IDLE) && start;
        req_en    = (state_q == ST_READ1) || (state_q == ST_READ2) ||
                    (state_q == ST_FINAL);
        poll_inc  = (state_q == ST_READ1) && xfer;
        done      = (state_q == ST_DONE);
        pass      = pass_q;
        final_data = data_q;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_READ1;
            ST_READ1:  if (xfer)  state_d = ST_CHECK1;
            ST_CHECK1: begin
                if (bit_match)     state_d = ST_FINAL;
                else if (tmo_seen) state_d = ST_READ2;
                else if (at_limit) state_d = ST_DONE;
                else               state_d = ST_READ1;
            end
            ST_READ2:  if (xfer)  state_d = ST_CHECK2;
            ST_CHECK2: state_d = bit_match ? ST_FINAL : ST_DONE;
            ST_FINAL:  if (xfer)  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the expected status bit at start.
    always_ff @(posedge clk) begin
        if (!rst_n)      exp_bit_q <= 1'b0;
        else if (accept) exp_bit_q <= is_erase ? 1'b1 : exp_data[STATUS_BIT];
    end

    // Result registers, written only on the way into DONE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            data_q <= '0;
        end else if (state_q == ST_FINAL && xfer) begin
            pass_q <= 1'b1;
            data_q <= rd_data;
        end else if (state_d == ST_DONE && state_q != ST_DONE) begin
            pass_q <= 1'b0;
            data_q <= cap_byte;
        end
    end
endmodule

// File: rtl/flash_poll_waiter.sv
// Top: waits for a flash program/erase to finish by polling one address,
// with a host-side limit on the number of polls.
// Assumes a synchronous read port where a transfer completes in a cycle with
// rd_req and rd_ready both high.
module flash_poll_waiter #(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned MAX_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        exp_data,
    input  logic              is_erase,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [7:0]        rd_data,
    output logic              done,
    output logic              pass,
    output logic [7:0]        final_data
);
    logic       accept;
    logic       req_en;
    logic       xfer;
    logic [7:0] cap_byte;
    logic       poll_inc;
    logic       at_limit;

    flash_poll_rdport #(.ADDR_W(ADDR_W)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_addr(accept),
        .new_addr (op_addr),
        .req_en   (req_en),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .xfer     (xfer),
        .cap_byte (cap_byte)
    );

    flash_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (poll_inc),
        .at_limit(at_limit)
    );

    flash_poll_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .exp_data  (exp_data),
        .is_erase  (is_erase),
        .xfer      (xfer),
        .rd_data   (rd_data),
        .cap_byte  (cap_byte),
        .at_limit  (at_limit),
        .accept    (accept),
        .req_en    (req_en),
        .poll_inc  (poll_inc),
        .done      (done),
        .pass      (pass),
        .final_data(final_data)
    );
endmodule

// File: rtl/flash_poll_waiter_chk.sv
// Checker: port-level properties of the poll waiter, bound to the top.
// Assumes it sees the top's ports unchanged.
module flash_poll_waiter_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              pass,
    input logic [7:0]        final_data
);
    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr));
    // R1
    idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);
    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req || $stable(rd_addr));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass) |-> done);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(final_data) |-> done);
endmodule

bind flash_poll_waiter flash_poll_waiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .done      (done),
    .pass      (pass),
    .final_data(final_data)
);

// File: tb/flash_poll_waiter_bench.sv
// Directed bench: a scripted memory model answers reads; each task runs one
// scenario and checks reads, addresses and the result.
module flash_poll_waiter_bench;
    localparam int unsigned AW   = 17;
    localparam int unsigned MAXP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    exp_data = '0;
    logic          is_erase = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ready = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          done;
    logic          pass;
    logic [7:0]    final_data;

    int checks = 0;
    int failures = 0;

    logic [7:0]    script [0:7];
    int            idx = 0;
    int            lat = 0;
    int            wait_cnt = 0;
    int            bad_addr = 0;
    logic [AW-1:0] want_addr = '0;

    always #4 clk = ~clk;

    flash_poll_waiter #(.ADDR_W(AW), .MAX_POLLS(MAXP)) u_flash_poll_waiter (
        .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr),
        .exp_data(exp_data), .is_erase(is_erase), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .pass(pass), .final_data(final_data)
    );

    // Memory model: answers a request after lat idle cycles, one byte per read.
    always @(negedge clk) begin
        if (rd_req && !rd_ready) begin
            if (rd_addr != want_addr) bad_addr++;
            if (wait_cnt >= lat) begin
                rd_ready = 1'b1;
                rd_data  = script[idx];
                idx++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            rd_ready = 1'b0;
            rd_data  = 8'h00;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d,
                          input logic er, input int latency);
        idx = 0; lat = latency; bad_addr = 0; want_addr = a;
        @(negedge clk);
        op_addr = a; exp_data = d; is_erase = er; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        check("R7 done seen", int'(done), 1);
    endtask

    task automatic expect_result(input string tag, input int reads,
                                 input logic p, input logic [7:0] d);
        check({tag, " reads"}, idx, reads);
        check({tag, " pass"}, int'(pass), int'(p));
        check({tag, " data"}, int'(final_data), int'(d));
        check("R1 address", bad_addr, 0);
    endtask

    task automatic t_reset;
        check("R9 rd_req", int'(rd_req), 0);
        check("R9 done", int'(done), 0);
        check("R9 pass", int'(pass), 0);
        check("R9 data", int'(final_data), 0);
    endtask

    task automatic t_first_match;
        script[0] = 8'h80; script[1] = 8'hA5;
        run_op(17'h01234, 8'hA5, 1'b0, 0);
        expect_result("R2 first match", 2, 1'b1, 8'hA5);
    endtask

    task automatic t_slow_complete;
        script[0] = 8'hC0; script[1] = 8'h80; script[2] = 8'h35;
        script[3] = 8'h35;
        run_op(17'h1FFFF, 8'h35, 1'b0, 3);
        expect_result("R3 repoll", 4, 1'b1, 8'h35);
    endtask

    task automatic t_tmo_then_match;
        script[0] = 8'hA0; script[1] = 8'h12; script[2] = 8'h12;
        run_op(17'h00400, 8'h12, 1'b0, 1);
        expect_result("R4 extra read match", 3, 1'b1, 8'h12);
    endtask

    task automatic t_tmo_then_fail;
        script[0] = 8'hA0; script[1] = 8'hA4; script[2] = 8'h55;
        run_op(17'h00401, 8'h12, 1'b0, 0);
        expect_result("R4 extra read fail", 2, 1'b0, 8'hA4);
    endtask

    task automatic t_erase;
        script[0] = 8'h00; script[1] = 8'hFF; script[2] = 8'hFF;
        run_op(17'h10000, 8'h00, 1'b1, 2);
        expect_result("R5 erase", 3, 1'b1, 8'hFF);
    endtask

    task automatic t_limit;
        for (int i = 0; i < 8; i++) script[i] = 8'h00 + 8'(i);
        run_op(17'h00077, 8'h80, 1'b0, 0);
        expect_result("R6 limit", MAXP, 1'b0, 8'h03);
    endtask

    task automatic t_hold;
        logic       p0;
        logic [7:0] d0;
        p0 = pass; d0 = final_data;
        for (int i = 0; i < 6; i++) @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
        check("R7 pass held", int'(pass), int'(p0));
        check("R7 data held", int'(final_data), int'(d0));
        check("R1 no req after done", int'(rd_req), 0);
    endtask

    task automatic t_late_start;
        script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h9C;
        script[3] = 8'h9C;
        idx = 0; lat = 2; bad_addr = 0; want_addr = 17'h00321;
        @(negedge clk);
        op_addr = 17'h00321; exp_data = 8'h9C; is_erase = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        op_addr = 17'h0ABCD; exp_data = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        check("R8 done seen", int'(done), 1);
        expect_result("R8 late start", 4, 1'b1, 8'h9C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_match();
        t_hold();
        t_slow_complete();
        t_tmo_then_match();
        t_tmo_then_fail();
        t_hold();
        t_erase();
        t_limit();
        t_hold();
        t_late_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule